// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block is the external bus interface of a small processor core in its single-chip (minimum) configuration. The core hands it one read or write request at a time. Each request carries a 20-bit address, a memory/I-O select, an upper-byte enable, write data, a two-bit segment code and the current interrupt-enable flag. The block runs the request as a four-state bus cycle on shared pins. The low sixteen lines carry the address first and then data. The top four lines carry the high address bits and then a status code. An address strobe marks the address phase. Active-low read and write strobes, a transceiver direction bit and an active-low transceiver enable frame the data phase.

Pin float is expressed as output enables for the pad tristates. `ad_oe` covers the sixteen shared lines and `ctl_oe` covers the high address/status lines, byte enable, strobes, memory/I-O, direction and transceiver enable. The address strobe always has a driver. A low READY stretches the cycle with wait states. A HOLD request is granted only between cycles: the bus floats and HLDA rises. An address demultiplexer latch is part of the block, so the full address of the running cycle stays available after the shared lines switch to data.

The request side uses a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The core must keep the request fields steady while `req_valid` is high and `req_ready` is low. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that the core must take.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: In the cycle after a request is accepted (T1), `ale` is 1 and `ad_oe` is 1. `ad_o` carries address bits 15..0, `ahi_o` carries address bits 19..16, and `bhe_n` is the inverse of the request's upper-byte enable.
- R2: From the cycle after T1 until the cycle ends, `ahi_o` carries status: bit 3 is 0, bit 2 is the request's interrupt-enable flag, and bits 1..0 are the segment code. `bhe_n` is 1 during the same span.
- R3: For a read, from the second cycle through the last wait state, `rd_n`=0, `ad_oe`=0, `dtr`=0 and `den_n`=0. `ad_i` is captured on the clock edge that ends the last T3/wait cycle and is returned on `rsp_rdata`.
- R4: For a write, from the second cycle through the last wait state, `ad_oe`=1, `ad_o` equals the write data, `wr_n`=0, `dtr`=1 and `den_n`=0.
- R5: Each READY-low sample at the end of T3 or of a wait state adds one wait state. With READY high, a cycle is exactly four clocks, so `rsp_valid` comes three clocks after `ale`, plus one clock per wait.
- R6: `req_ready` is 1 only in idle or in the final cycle T4, and only while `hold` is 0. An accepted request puts `ale` high in the next cycle, so a request taken in T4 runs back-to-back.
- R7: `hold` is sampled only in idle or in T4, so a running cycle always completes first. In the cycle after a grant, `hlda`=1, `ad_oe`=0, `ctl_oe`=0 and `ale`=0, and no request is accepted. One cycle after `hold` falls, `hlda` is 0.
- R8: `mio` is 1 for a memory cycle and 0 for an I/O cycle (request select `req_io`=1), and is held for the whole cycle.
- R9: From the cycle after T1 until the next T1, `lat_addr` holds the full 20-bit address of the last cycle.
- R10: `rd_n`, `wr_n` and `den_n` are 1 in idle, T1, T4 and hold, and `rd_n` and `wr_n` are never 0 together.
- R11: `rsp_valid` pulses for exactly one cycle, in T4, once per accepted request, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O port, 0 = memory |
| req_bhe | input | 1 | upper data byte takes part |
| req_addr | input | 20 | byte address |
| req_wdata | input | 16 | write data |
| req_seg | input | 2 | segment code for status |
| req_ifl | input | 1 | interrupt-enable flag for status |
| rsp_valid | output | 1 | cycle done pulse |
| rsp_rdata | output | 16 | read data |
| ad_o | output | 16 | shared address/data lines, driven value |
| ad_i | input | 16 | shared address/data lines, received value |
| ad_oe | output | 1 | drive enable for ad_o |
| ahi_o | output | 4 | high address / status lines |
| bhe_n | output | 1 | upper byte enable, active low (status 1 after T1) |
| ale | output | 1 | address strobe, never floated |
| rd_n | output | 1 | read strobe, active low |
| wr_n | output | 1 | write strobe, active low |
| mio | output | 1 | 1 memory, 0 I/O |
| dtr | output | 1 | transceiver direction, 1 = transmit |
| den_n | output | 1 | transceiver enable, active low |
| ctl_oe | output | 1 | drive enable for control, status and high address |
| ready | input | 1 | 0 inserts wait states |
| hold | input | 1 | bus hold request |
| hlda | output | 1 | bus hold granted |
| lat_addr | output | 20 | demultiplexed address of the current cycle |

## Verification
The bench gives the memory model a different wait count for each cycle. A design that sampled READY once, or in the wrong state, would put `rsp_valid` on the wrong clock or capture read data before it was valid. A write followed at once by a read of the same word, with no idle cycle between, would expose a design that loses the T4 acceptance or leaves the write data driven during the read turnaround. HOLD is raised while a cycle is in its wait states. A design that granted it at once would float the strobes in the middle of the cycle, and one that ignored the grant window would start a pending request while `hlda` is high. The status and latch checks in T2 would catch a design that left address on the high lines or let the latch follow the data phase.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4, ST_HOLD
  } bst_e;

  typedef struct packed {
    logic       wr;
    logic       io;
    logic       bhe;
    logic [1:0] seg;
    logic       ifl;
  } req_attr_t;
endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hold,
  input  logic ready,
  output bst_e state,
  output logic req_ready,
  output logic capture
);
  bst_e nxt;
  logic gap;

  assign gap       = (state == ST_IDLE) || (state == ST_T4);
  assign req_ready = gap && !hold;
  assign capture   = ((state == ST_T3) || (state == ST_TW)) && ready;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE, ST_T4: begin
        if (hold)           nxt = ST_HOLD;
        else if (req_valid) nxt = ST_T1;
        else                nxt = ST_IDLE;
      end
      ST_T1:         nxt = ST_T2;
      ST_T2:         nxt = ST_T3;
      ST_T3, ST_TW:  nxt = ready ? ST_T4 : ST_TW;
      ST_HOLD:       nxt = hold ? ST_HOLD : ST_IDLE;
      default:       nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R5
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_T3 || state == ST_TW) && !ready) |=> (state == ST_TW));

  // R7
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap && hold) |=> (state == ST_HOLD));

  // R7
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T2 && hold) |=> (state == ST_T3));
endmodule

// File: rtl/bcc_drive.sv
module bcc_drive
  import bcc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  bst_e            state,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  req_attr_t       attr,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe,
  output logic [HW-1:0]   ahi_o,
  output logic            bhe_n,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            mio,
  output logic            dtr,
  output logic            den_n,
  output logic            ctl_oe
);
  logic [HW-1:0] status;
  logic          data_ph;

  assign status  = HW'({1'b0, attr.ifl, attr.seg});
  assign data_ph = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);

  always_comb begin
    ad_o   = '0;
    ad_oe  = 1'b0;
    ahi_o  = '0;
    bhe_n  = 1'b1;
    ale    = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    mio    = !attr.io;
    dtr    = attr.wr;
    den_n  = 1'b1;
    ctl_oe = (state != ST_HOLD);
    unique case (state)
      ST_T1: begin
        ale   = 1'b1;
        ad_oe = 1'b1;
        ad_o  = addr[DW-1:0];
        ahi_o = addr[AW-1:DW];
        bhe_n = !attr.bhe;
      end
      ST_T2, ST_T3, ST_TW, ST_T4: begin
        ahi_o = status;
        if (data_ph) begin
          den_n = 1'b0;
          if (attr.wr) begin
            ad_oe = 1'b1;
            ad_o  = wdata;
            wr_n  = 1'b0;
          end else begin
            rd_n  = 1'b0;
          end
        end
      end
      default: begin
        mio = 1'b1;
        dtr = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bcc_demux.sv
module bcc_demux #(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [DW-1:0] ad_o,
  input  logic [HW-1:0] ahi_o,
  output logic [AW-1:0] lat_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lat_addr <= '0;
    else if (ale) lat_addr <= {ahi_o, ad_o};
  end

  // R9
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(lat_addr));
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_bhe,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_seg,
  input  logic          req_ifl,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] ad_o,
  input  logic [DW-1:0] ad_i,
  output logic          ad_oe,
  output logic [HW-1:0] ahi_o,
  output logic          bhe_n,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          mio,
  output logic          dtr,
  output logic          den_n,
  output logic          ctl_oe,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda,
  output logic [AW-1:0] lat_addr
);
  bst_e          state;
  logic          capture;
  logic          accept;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  req_attr_t     attr_q;

  assign accept    = req_valid && req_ready;
  assign rsp_valid = (state == ST_T4);
  assign hlda      = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      attr_q    <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        attr_q  <= '{wr: req_write, io: req_io, bhe: req_bhe,
                     seg: req_seg, ifl: req_ifl};
      end
      if (capture && !attr_q.wr) rsp_rdata <= ad_i;
    end
  end

  bcc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hold(hold),
    .ready(ready), .state(state), .req_ready(req_ready), .capture(capture)
  );

  bcc_drive #(.AW(AW), .DW(DW)) u_drive (
    .state(state), .addr(addr_q), .wdata(wdata_q), .attr(attr_q),
    .ad_o(ad_o), .ad_oe(ad_oe), .ahi_o(ahi_o), .bhe_n(bhe_n), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .dtr(dtr), .den_n(den_n),
    .ctl_oe(ctl_oe)
  );

  bcc_demux #(.AW(AW), .DW(DW)) u_demux (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_o(ad_o), .ahi_o(ahi_o),
    .lat_addr(lat_addr)
  );

  // R10
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (rd_n && wr_n && !ad_oe && !ctl_oe && !ale));

  // R1
  ale_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && ad_oe && ctl_oe));

  // R6
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_io = 0, req_bhe = 0, req_ifl = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_seg = '0;
  logic          req_ready, rsp_valid, ad_oe, bhe_n, ale, rd_n, wr_n, mio, dtr, den_n, ctl_oe, hlda;
  logic [DW-1:0] rsp_rdata, ad_o, ad_i;
  logic [3:0]    ahi_o;
  logic [AW-1:0] lat_addr;
  logic          ready = 1'b1;
  logic          hold = 1'b0;

  bus_cycle_ctrl u_bus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_io(req_io), .req_bhe(req_bhe), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_seg(req_seg), .req_ifl(req_ifl),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ad_o(ad_o), .ad_i(ad_i),
    .ad_oe(ad_oe), .ahi_o(ahi_o), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .mio(mio), .dtr(dtr), .den_n(den_n), .ctl_oe(ctl_oe),
    .ready(ready), .hold(hold), .hlda(hlda), .lat_addr(lat_addr)
  );

  typedef struct {
    logic          wr;
    logic          io;
    logic          bhe;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    seg;
    logic          ifl;
    int            waits;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  int scnt;

  function automatic logic [DW-1:0] seed(int i);
    return DW'(i * 16'h0101) ^ 16'hA5C3;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with per-cycle wait count
  always_comb ad_i = (!rd_n) ? mem[lat_addr[8:1]] : '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed(i);
      scnt <= 0;
    end else begin
      if (!wr_n && ready) mem[lat_addr[8:1]] <= ad_o;
      scnt <= (!rd_n || !wr_n) ? scnt + 1 : 0;
    end
  end

  // driver: call at a negedge; returns at the negedge after acceptance
  task automatic issue(bit wr, bit io, bit bhe, logic [AW-1:0] a, logic [DW-1:0] d,
                       logic [1:0] s, bit f, int w);
    item_t it;
    it.wr = wr; it.io = io; it.bhe = bhe; it.addr = a; it.seg = s; it.ifl = f; it.waits = w;
    if (wr) begin it.data = d; shadow[a[8:1]] = d; end
    else    it.data = shadow[a[8:1]];
    q.push_back(it);
    req_valid = 1; req_write = wr; req_io = io; req_bhe = bhe;
    req_addr = a; req_wdata = d; req_seg = s; req_ifl = f;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    int ph;
    bit in_cyc;
    ph = 0; in_cyc = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin ready = 1; continue; end
      if (hlda) chk("R7 float in hold", {27'd0, ad_oe, ctl_oe, rd_n, wr_n, ale}, 32'b00110);
      if (ale) begin
        ph = 0; in_cyc = 1;
        if (q.size() > 0) begin
          chk("R1 low addr", ad_o, q[0].addr[15:0]);
          chk("R1 high addr", ahi_o, q[0].addr[19:16]);
          chk("R1 bhe_n", bhe_n, !q[0].bhe);
          chk("R1 ad_oe", ad_oe, 1);
          chk("R8 mio", mio, !q[0].io);
          chk("R10 strobes idle in T1", {rd_n, wr_n, den_n}, 3'b111);
        end else chk("R11 unexpected cycle", 1, 0);
      end else if (in_cyc) ph++;
      if (in_cyc && ph == 1 && q.size() > 0) begin
        chk("R2 status", ahi_o, {1'b0, q[0].ifl, q[0].seg});
        chk("R2 S7", bhe_n, 1);
        chk("R8 mio held", mio, !q[0].io);
        chk("R9 latched addr", lat_addr, q[0].addr);
        chk("R6 busy", req_ready, 0);
        if (q[0].wr) begin
          chk("R4 write pins", {ad_oe, wr_n, rd_n, dtr, den_n}, 5'b10110);
          chk("R4 write data", ad_o, q[0].data);
        end else
          chk("R3 read pins", {ad_oe, rd_n, wr_n, dtr, den_n}, 5'b00100);
      end
      if (rsp_valid) begin
        if (q.size() == 0) chk("R11 stray response", 1, 0);
        else begin
          chk("R5 cycle length", ph, 3 + q[0].waits);
          chk("R10 strobes off in T4", {rd_n, wr_n, den_n}, 3'b111);
          chk("R9 latch at T4", lat_addr, q[0].addr);
          if (!q[0].wr) chk("R3 read data", rsp_rdata, q[0].data);
          void'(q.pop_front());
        end
        in_cyc = 0;
      end
      ready = (q.size() == 0) || (scnt > q[0].waits);
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = seed(i);
    repeat (3) @(negedge clk);
    // reset state (R6, R10, R7)
    chk("R10 reset strobes", {rd_n, wr_n, den_n, ale}, 4'b1110);
    chk("R7 reset hlda", hlda, 0);
    chk("R6 reset ready", req_ready, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // write then read, READY high (R5 no effect)
    issue(1, 0, 1, 20'h5_0246, 16'hBEEF, 2'd2, 1, 0);
    req_valid = 0;
    repeat (6) @(negedge clk);
    issue(0, 0, 1, 20'h5_0246, 16'h0, 2'd2, 1, 0);
    req_valid = 0;
    repeat (6) @(negedge clk);

    // I/O read with wait states, upper byte off
    issue(0, 1, 0, 20'h0_0031, 16'h0, 2'd1, 0, 3);
    req_valid = 0;
    repeat (10) @(negedge clk);

    // back-to-back: write with waits, then read of the same word (R6)
    issue(1, 0, 0, 20'hF_FF10, 16'h1357, 2'd3, 0, 2);
    issue(0, 0, 1, 20'hF_FF10, 16'h0, 2'd0, 1, 0);
    req_valid = 0;
    repeat (8) @(negedge clk);
    chk("R11 queue drained", q.size(), 0);

    // hold during a waited read (R7)
    issue(0, 0, 1, 20'h3_0100, 16'h0, 2'd3, 1, 4);
    req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    hold = 1;
    do @(negedge clk); while (!rsp_valid);
    @(negedge clk);
    chk("R7 grant after cycle", hlda, 1);
    fork
      issue(1, 0, 1, 20'h3_0100, 16'h2468, 2'd0, 0, 1);
    join_none
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 no cycle in hold", {hlda, ale, req_ready}, 3'b100);
    end
    hold = 0;
    @(negedge clk);
    chk("R7 release", hlda, 0);
    wait fork;
    req_valid = 0;
    repeat (6) @(negedge clk);
    issue(0, 0, 1, 20'h3_0100, 16'h0, 2'd3, 1, 1);
    req_valid = 0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule